// File: doc/BRIEF.md
# Battery Charge Sequencing Controller

This block picks the charge current setpoint for a rechargeable battery pack. It works from digitized battery voltage and temperature samples, a once-per-minute tick, a charger-present input and the instrument on/off status. With the instrument off, it runs a fast charge until a temperature-slope detector reports the pack full. It then runs a timed top-off phase, followed by a continuous maintenance trickle. With the instrument on, it holds a small constant current. A battery temperature above a hot limit forces the setpoint to off while the sequence keeps its place.

On request, a refresh procedure fully charges the pack, then drains it through a discharge path down to a threshold voltage, then charges it fully again, and then drops to the maintenance trickle. The block also flags a low battery and requests a power-off when the voltage falls below fixed limits.

The analog charge loop turns the encoded current level into a real current. Samples arrive on a valid/ready stream. The block takes every sample it is offered, so `samp_ready_o` is always high and a producer never has to wait. A sample counts as accepted on any clock edge where `samp_valid_i` is high.

Top module: `batt_charge_seq`

## Requirements
- R1: `samp_ready_o` is high at all times after reset. The voltage and temperature of the latest accepted sample are used from the cycle after it is accepted. Before any sample is accepted, the voltage reads as its maximum code and the temperature as zero.
- R2: `low_batt_o` is high exactly when the latest voltage (in mV) is below LOW_MV (6900).
- R3: `shutdown_o` is high exactly when the latest voltage is below OFF_MV (6000).
- R4: Level codes on `chg_level_o` are: 0 off, 1 = 60 mA, 2 = 90 mA, 3 = 0.35 A, 4 = 1 A. When `chg_ok_i` is low, the level is 0, `dis_en_o` is low, and the sequence returns to its start.
- R5: With the charger present and `tool_on_i` high, and outside a refresh, the level is 1.
- R6: With the charger present and the tool off, the level is 4 until a full event. A full event happens on a tick when the latest temperature exceeds the temperature latched at the previous tick by more than SLOPE_LIM units. Temperature is in 0.25 °C units, and SLOPE_LIM = 3 means 0.75 °C per minute. The first tick after reset only records a temperature.
- R7: After a full event, the level is 3 for PHASE_MIN ticks and then 2 continuously.
- R8: A temperature above HOT_LIM (200, meaning 50 °C) forces the level to 0 without moving the sequence. The level returns once the temperature is at or below the limit.
- R9: A refresh pulse with the charger present starts a refresh. The refresh runs level 4 until a full event. It then runs level 0 with `dis_en_o` high until the voltage is below DIS_MV (6400). It then runs level 4 until a full event, and then level 2. The tool-on input and further refresh pulses are ignored during a refresh.
- R10: Removing the charger during the 0.35 A phase restarts the phase timer. A later top-off phase again lasts a full PHASE_MIN ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| samp_valid_i | input | 1 | Sample stream valid |
| samp_ready_o | output | 1 | Sample stream ready (always high) |
| samp_mv_i | input | MV_W | Battery voltage in mV |
| samp_temp_i | input | TEMP_W | Battery temperature, 0.25 °C units |
| tick_min_i | input | 1 | One-cycle pulse once per minute |
| chg_ok_i | input | 1 | Charger present and adapter voltage valid |
| tool_on_i | input | 1 | Instrument is switched on |
| refresh_req_i | input | 1 | One-cycle refresh request |
| chg_level_o | output | 3 | Encoded charge current level |
| dis_en_o | output | 1 | Forced discharge enable |
| low_batt_o | output | 1 | Low battery warning |
| shutdown_o | output | 1 | Forced power-off request |

## Verification
The bench builds the block with PHASE_MIN = 4 and keeps the default thresholds. The short phase puts the end of the top-off phase, and its restart after the charger is removed, only a few ticks away. Voltages are swept one millivolt at a time across each threshold. Temperatures are swept one unit at a time across the hot limit. Temperature steps from 0 to 6 units are swept across the slope limit, so every comparison boundary is hit on both sides.

// File: rtl/batt_pkg.sv
package batt_pkg;
  typedef enum logic [2:0] {
    LVL_OFF = 3'd0,
    LVL_60  = 3'd1,
    LVL_90  = 3'd2,
    LVL_350 = 3'd3,
    LVL_1A  = 3'd4
  } lvl_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ON60,
    ST_FAST,
    ST_TOP,
    ST_HOLD,
    ST_RF1,
    ST_RDIS,
    ST_RF2
  } st_e;
endpackage

// File: rtl/bcs_sample_reg.sv
module bcs_sample_reg #(
  parameter int MV_W   = 13,
  parameter int TEMP_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [MV_W-1:0]   mv_i,
  input  logic [TEMP_W-1:0] temp_i,
  output logic [MV_W-1:0]   mv_q,
  output logic [TEMP_W-1:0] temp_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mv_q   <= '1;
      temp_q <= '0;
    end else if (valid_i) begin
      mv_q   <= mv_i;
      temp_q <= temp_i;
    end
  end
endmodule

// File: rtl/bcs_slope_det.sv
module bcs_slope_det #(
  parameter int TEMP_W    = 10,
  parameter int SLOPE_LIM = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [TEMP_W-1:0] temp_i,
  output logic              full_o
);
  localparam int EW = TEMP_W + 1;

  logic [TEMP_W-1:0] prev_q;
  logic              seen_q;
  logic [EW-1:0]     lim_w;
  logic              rise_w;

  assign lim_w  = {1'b0, prev_q} + EW'(SLOPE_LIM);
  assign rise_w = {1'b0, temp_i} > lim_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      seen_q <= 1'b0;
      full_o <= 1'b0;
    end else begin
      full_o <= tick_i && seen_q && rise_w;
      if (tick_i) begin
        prev_q <= temp_i;
        seen_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bcs_phase_timer.sv
module bcs_phase_timer #(
  parameter int PHASE_MIN = 120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int CW = $clog2(PHASE_MIN + 1);
  localparam logic [CW-1:0] LAST = CW'(PHASE_MIN - 1);

  logic [CW-1:0] cnt_q;

  assign done_o = run_i && tick_i && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!run_i)       cnt_q <= '0;
    else if (tick_i && !done_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/bcs_fsm.sv
module bcs_fsm
  import batt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic chg_ok_i,
  input  logic tool_on_i,
  input  logic refresh_i,
  input  logic full_i,
  input  logic drained_i,
  input  logic done_i,
  output st_e  st_o
);
  st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (!chg_ok_i) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: st_d = refresh_i ? ST_RF1 : (tool_on_i ? ST_ON60 : ST_FAST);
        ST_ON60: if (refresh_i) st_d = ST_RF1;
                 else if (!tool_on_i) st_d = ST_FAST;
        ST_FAST: if (refresh_i) st_d = ST_RF1;
                 else if (tool_on_i) st_d = ST_ON60;
                 else if (full_i) st_d = ST_TOP;
        ST_TOP:  if (refresh_i) st_d = ST_RF1;
                 else if (tool_on_i) st_d = ST_ON60;
                 else if (done_i) st_d = ST_HOLD;
        ST_HOLD: if (refresh_i) st_d = ST_RF1;
                 else if (tool_on_i) st_d = ST_ON60;
        ST_RF1:  if (full_i) st_d = ST_RDIS;
        ST_RDIS: if (drained_i) st_d = ST_RF2;
        ST_RF2:  if (full_i) st_d = ST_HOLD;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign st_o = st_q;
endmodule

// File: rtl/batt_charge_seq.sv
module batt_charge_seq
  import batt_pkg::*;
#(
  parameter int MV_W      = 13,
  parameter int TEMP_W    = 10,
  parameter int LOW_MV    = 6900,
  parameter int OFF_MV    = 6000,
  parameter int DIS_MV    = 6400,
  parameter int HOT_LIM   = 200,
  parameter int SLOPE_LIM = 3,
  parameter int PHASE_MIN = 120
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              samp_valid_i,
  output logic              samp_ready_o,
  input  logic [MV_W-1:0]   samp_mv_i,
  input  logic [TEMP_W-1:0] samp_temp_i,
  input  logic              tick_min_i,
  input  logic              chg_ok_i,
  input  logic              tool_on_i,
  input  logic              refresh_req_i,
  output logic [2:0]        chg_level_o,
  output logic              dis_en_o,
  output logic              low_batt_o,
  output logic              shutdown_o
);
  localparam logic [MV_W-1:0]   LOW_C = MV_W'(LOW_MV);
  localparam logic [MV_W-1:0]   OFF_C = MV_W'(OFF_MV);
  localparam logic [MV_W-1:0]   DIS_C = MV_W'(DIS_MV);
  localparam logic [TEMP_W-1:0] HOT_C = TEMP_W'(HOT_LIM);

  logic [MV_W-1:0]   mv_w;
  logic [TEMP_W-1:0] temp_w;
  logic              full_w, done_w, hot_w, drained_w;
  st_e               st_w;
  lvl_e              lvl_w;

  assign samp_ready_o = 1'b1;

  bcs_sample_reg #(.MV_W(MV_W), .TEMP_W(TEMP_W)) u_samp (
    .clk(clk), .rst_n(rst_n), .valid_i(samp_valid_i),
    .mv_i(samp_mv_i), .temp_i(samp_temp_i),
    .mv_q(mv_w), .temp_q(temp_w)
  );

  bcs_slope_det #(.TEMP_W(TEMP_W), .SLOPE_LIM(SLOPE_LIM)) u_slope (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_min_i),
    .temp_i(temp_w), .full_o(full_w)
  );

  bcs_phase_timer #(.PHASE_MIN(PHASE_MIN)) u_timer (
    .clk(clk), .rst_n(rst_n), .run_i(st_w == ST_TOP),
    .tick_i(tick_min_i), .done_o(done_w)
  );

  bcs_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .chg_ok_i(chg_ok_i), .tool_on_i(tool_on_i),
    .refresh_i(refresh_req_i), .full_i(full_w), .drained_i(drained_w),
    .done_i(done_w), .st_o(st_w)
  );

  assign low_batt_o = mv_w < LOW_C;
  assign shutdown_o = mv_w < OFF_C;
  assign drained_w  = mv_w < DIS_C;
  assign hot_w      = temp_w > HOT_C;

  always_comb begin
    unique case (st_w)
      ST_ON60:                 lvl_w = LVL_60;
      ST_FAST, ST_RF1, ST_RF2: lvl_w = LVL_1A;
      ST_TOP:                  lvl_w = LVL_350;
      ST_HOLD:                 lvl_w = LVL_90;
      default:                 lvl_w = LVL_OFF;
    endcase
  end

  assign chg_level_o = hot_w ? LVL_OFF : lvl_w;
  assign dis_en_o    = (st_w == ST_RDIS);
endmodule

// File: rtl/bcs_chk.sv
module bcs_chk #(
  parameter int MV_W   = 13,
  parameter int LOW_MV = 6900
) (
  input logic            clk,
  input logic            rst_n,
  input logic            samp_valid_i,
  input logic [MV_W-1:0] samp_mv_i,
  input logic            chg_ok_i,
  input logic [2:0]      chg_level_o,
  input logic            dis_en_o,
  input logic            low_batt_o,
  input logic            shutdown_o,
  input logic            hot
);
  // R9
  dis_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dis_en_o |-> chg_level_o == 3'd0);
  // R8
  hot_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hot |-> chg_level_o == 3'd0);
  // R3
  shut_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_o |-> low_batt_o);
  // R4
  nochg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chg_ok_i |=> (chg_level_o == 3'd0) && !dis_en_o);
  // R2
  low_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_valid_i && samp_mv_i < MV_W'(LOW_MV)) |=> low_batt_o);
endmodule

bind batt_charge_seq bcs_chk #(.MV_W(MV_W), .LOW_MV(LOW_MV)) u_chk (
  .clk(clk), .rst_n(rst_n), .samp_valid_i(samp_valid_i), .samp_mv_i(samp_mv_i),
  .chg_ok_i(chg_ok_i), .chg_level_o(chg_level_o), .dis_en_o(dis_en_o),
  .low_batt_o(low_batt_o), .shutdown_o(shutdown_o), .hot(hot_w)
);

// File: tb/batt_charge_seq_tb.sv
module batt_charge_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PH = 4;

  logic        clk = 0, rst_n = 0;
  logic        samp_valid = 0, tick = 0, chg = 0, tool = 0, rfr = 0;
  logic [12:0] mv = 0;
  logic [9:0]  temp = 0;
  logic        ready, dis, low, shut;
  logic [2:0]  lvl;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  batt_charge_seq #(.PHASE_MIN(PH)) u_dut (
    .clk(clk), .rst_n(rst_n), .samp_valid_i(samp_valid), .samp_ready_o(ready),
    .samp_mv_i(mv), .samp_temp_i(temp), .tick_min_i(tick), .chg_ok_i(chg),
    .tool_on_i(tool), .refresh_req_i(rfr), .chg_level_o(lvl), .dis_en_o(dis),
    .low_batt_o(low), .shutdown_o(shut)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; samp_valid = 0; tick = 0; chg = 0; tool = 0; rfr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic settle(); repeat (3) @(negedge clk); endtask

  task automatic send(input int v, input int t);
    @(negedge clk); samp_valid = 1; mv = 13'(v); temp = 10'(t);
    @(negedge clk); samp_valid = 0;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1; @(negedge clk); tick = 0;
  endtask

  task automatic pulse_rfr();
    @(negedge clk); rfr = 1; @(negedge clk); rfr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 ready", ready, 1);
    chk("R1 low at reset", low, 0);
    chk("R1 shut at reset", shut, 0);
    chk("R4 level at reset", lvl, 0);
    chk("R4 dis at reset", dis, 0);

    // R2 R3 threshold sweeps
    for (int v = 5995; v <= 6005; v++) begin
      send(v, 100); settle();
      chk("R3 shutdown", shut, (v < 6000) ? 1 : 0);
      chk("R2 low", low, (v < 6900) ? 1 : 0);
    end
    for (int v = 6895; v <= 6905; v++) begin
      send(v, 100); settle();
      chk("R2 low", low, (v < 6900) ? 1 : 0);
      chk("R3 shutdown", shut, 0);
      chk("R1 ready", ready, 1);
    end

    // R5 tool on
    chg = 1; tool = 1; settle();
    chk("R5 tool on level", lvl, 1);
    tool = 0; settle();
    chk("R6 fast level", lvl, 4);
    chg = 0; settle();
    chk("R4 charger removed", lvl, 0);

    // R6 slope sweep
    for (int d = 0; d <= 6; d++) begin
      do_reset(); chg = 1;
      send(7500, 100); pulse_tick(); settle();
      chk("R6 first tick records only", lvl, 4);
      send(7500, 100 + d); pulse_tick(); settle();
      chk("R6 slope detect", lvl, (d > 3) ? 3 : 4);
    end

    // R7 timed top-off
    do_reset(); chg = 1;
    send(7500, 100); pulse_tick(); send(7500, 104); pulse_tick(); settle();
    chk("R7 top-off entered", lvl, 3);
    for (int k = 1; k < PH; k++) begin
      pulse_tick(); settle();
      chk("R7 top-off held", lvl, 3);
    end
    pulse_tick(); settle();
    chk("R7 maintenance", lvl, 2);
    pulse_tick(); pulse_tick(); settle();
    chk("R7 maintenance held", lvl, 2);

    // R10 timer restart
    do_reset(); chg = 1;
    send(7500, 100); pulse_tick(); send(7500, 104); pulse_tick(); settle();
    pulse_tick(); pulse_tick();
    chg = 0; settle();
    chk("R4 removal mid top-off", lvl, 0);
    chg = 1; settle();
    chk("R10 back to fast", lvl, 4);
    send(7500, 108); pulse_tick(); settle();
    chk("R10 top-off again", lvl, 3);
    for (int k = 1; k < PH; k++) begin
      pulse_tick(); settle();
      chk("R10 full phase length", lvl, 3);
    end
    pulse_tick(); settle();
    chk("R10 phase end", lvl, 2);

    // R8 hot sweep
    do_reset(); chg = 1;
    for (int t = 198; t <= 202; t++) begin
      send(7500, t); settle();
      chk("R8 hot limit", lvl, (t > 200) ? 0 : 4);
    end
    send(7500, 150); settle();
    chk("R8 recovers", lvl, 4);

    // R9 refresh
    do_reset(); chg = 1; tool = 1; settle();
    chk("R5 before refresh", lvl, 1);
    pulse_rfr(); settle();
    chk("R9 refresh charge ignores tool", lvl, 4);
    send(7500, 100); pulse_tick(); send(7500, 104); pulse_tick(); settle();
    chk("R9 discharge level", lvl, 0);
    chk("R9 discharge enable", dis, 1);
    pulse_rfr(); settle();
    chk("R9 second request ignored", dis, 1);
    send(6400, 104); settle();
    chk("R9 at threshold still discharging", dis, 1);
    send(6399, 104); settle();
    chk("R9 recharge level", lvl, 4);
    chk("R9 recharge dis off", dis, 0);
    tool = 0;
    send(6399, 108); pulse_tick(); settle();
    chk("R9 maintenance after refresh", lvl, 2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule